// File: doc/BRIEF.md
# Frame-Locked Digital PLL Core

This block keeps a line-rate clock in step with an 8 kHz frame reference. A counter chain divides a master clock down to the line clock and then to an internal 8 kHz comparison signal. The block is clocked at twice the master rate, so each master period is two clock cycles. Stretching or shrinking the master clock by half a period therefore means holding the chain for one cycle or skipping one cycle.

On every falling edge of the reference, the block captures two values: the level of its own 8 kHz signal and a correction strobe. The strobe is low inside a dead-band centred on the internal falling edge. After the capture the block makes at most one adjustment in the frame, and that adjustment takes effect at a fixed phase. The dead-band is deliberate. While the reference wanders inside it the loop does not follow, so low-frequency jitter and wander are filtered out. A lock flag reports a run of frames that needed no correction.

The same core serves two variants. The T1 variant divides by 8 and then by 193, giving 1.544 MHz from 12.352 MHz. The CEPT variant divides by 8 and then by 256, giving 2.048 MHz from 16.384 MHz. The variant is chosen with the divider and dead-band parameters. The defaults and all numbers below are for the T1 variant, where one frame is 3088 cycles.

Top module: `frame_dpll`

## Requirements
- R1: The line clock has a period of 2*LINE_DIV cycles (16). The comparison output falls once every FRAME_DIV line periods (3088 cycles), at frame phase 0, and is high for frame phases at or above (FRAME_DIV/2)*2*LINE_DIV (1536). Each frame holds exactly FRAME_DIV line-clock rising edges.
- R2: The reference passes a two-stage synchroniser. A high-to-low change presented while the frame phase is p is judged at phase p+2. A rising edge has no effect.
- R3: The strobe is low when the judged phase is below DEADBAND (4) or at or above frame length minus DEADBAND (3084). A frame judged there is not corrected, so two frames span exactly 6176 cycles.
- R4: When the strobe is high and the comparison level is low, one cycle is added to the chain. Two frames then span 6177 cycles.
- R5: When the strobe is high and the comparison level is high, one cycle is removed from the chain. Two frames then span 6175 cycles.
- R6: A correction is applied once, when the frame phase reaches 1536. A decision taken at or after that point applies in the next frame. Line clock and comparison output shift together, so each frame still holds FRAME_DIV line-clock edges.
- R7: When a capture falls in the same cycle as the application of an earlier decision, the earlier decision is applied and the new one is kept for the next frame.
- R8: With a constant reference no corrections occur: every frame is exactly 3088 cycles and the lock flag stays low.
- R9: The lock flag rises after LOCK_FRAMES (8) consecutive captures with the strobe low, and not before.
- R10: A capture with the strobe high clears the lock flag in the next cycle and restarts the count.
- R11: A synchronous active-low reset sets the frame phase to 0, the line clock, comparison output and lock flag to 0, and drops any pending decision. After release, the first comparison fall comes 3088 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_ref_i | input | 1 | 8 kHz frame reference, asynchronous |
| line_clk_o | output | 1 | Line clock (master divided by LINE_DIV) |
| cmp8k_o | output | 1 | Internal 8 kHz comparison signal |
| locked_o | output | 1 | High after a run of uncorrected frames |

## Verification
Capturing a new reference edge and applying the previous frame's correction can fall in the same cycle. This happens when a reference edge is judged exactly at phase 1536 while an earlier shrink decision is still pending. The bench sets up the pending shrink by placing a reference fall near the end of one frame. In the next frame it places a second fall so that the edge is judged at phase 1536. It then requires the three frames involved to span 3*3088-2 cycles, which proves that both shrinks took effect in successive frames. Dead-band boundary phases 3/4 and 3083/3084 are also exercised, each by its own vector.

// File: rtl/frame_dpll_pkg.sv
// Shared types for the frame-locked DPLL.
// Assumes: a correction is one of three kinds and depends only on two sampled bits.
package frame_dpll_pkg;

    typedef enum logic [1:0] {
        CORR_NONE    = 2'd0,
        CORR_STRETCH = 2'd1,
        CORR_SHRINK  = 2'd2
    } corr_e;

    // Map the sampled strobe and comparison level to a correction kind.
    function automatic corr_e decide(input logic strobe, input logic level);
        corr_e r;
        if (!strobe)     r = CORR_NONE;
        else if (!level) r = CORR_STRETCH;
        else             r = CORR_SHRINK;
        return r;
    endfunction

endpackage

// File: rtl/frame_dpll_ref_sync.sv
// Reference synchroniser and falling-edge detector.
// Brings the asynchronous frame reference through STAGES flip-flops, then flags
// a high-to-low transition for one cycle. Assumes the reference has at most one
// falling edge per frame. Reset clears the chain, so no edge is reported
// just after reset, whatever level the reference holds.
module frame_dpll_ref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic fall_o
);

    logic [STAGES:0] chain_q;

    // Shift the reference through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], ref_i};
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R2: a detected edge lasts one cycle only
    assert_single_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/frame_dpll_divider.sv
// Divider chain: a sub-counter of 2*LINE_DIV cycles makes the line clock, and a
// line counter of FRAME_DIV periods makes the 8 kHz comparison signal.
// A stretch holds the chain for one cycle; a shrink advances the sub-counter by
// two. Both come only at the apply point, where the sub-counter is 0.
// Also produces the correction strobe (low inside the dead-band around the
// comparison fall). Assumes LINE_DIV >= 2 and DEADBAND < half a frame.
module frame_dpll_divider #(
    parameter int unsigned LINE_DIV  = 8,
    parameter int unsigned FRAME_DIV = 193,
    parameter int unsigned DEADBAND  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_i,
    input  logic shrink_i,
    output logic line_clk_o,
    output logic cmp8k_o,
    output logic strobe_o,
    output logic at_apply_o,
    output logic wrap_o
);

    localparam int unsigned SUB_N       = 2 * LINE_DIV;
    localparam int unsigned SUB_W       = $clog2(SUB_N);
    localparam int unsigned LINE_W      = $clog2(FRAME_DIV);
    localparam int unsigned FRAME_TICKS = SUB_N * FRAME_DIV;
    localparam int unsigned PH_W        = $clog2(FRAME_TICKS);
    localparam int unsigned APPLY_LINE  = FRAME_DIV / 2;

    logic [SUB_W-1:0]  sub_q;
    logic [LINE_W-1:0] line_q;
    logic [PH_W-1:0]   phase;
    logic              sub_last;
    logic              line_last;

    assign sub_last  = (sub_q == SUB_W'(SUB_N - 1));
    assign line_last = (line_q == LINE_W'(FRAME_DIV - 1));

    // Advance the chain by one, hold it, or skip one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            line_q <= '0;
        end else if (stretch_i) begin
            sub_q  <= sub_q;
            line_q <= line_q;
        end else if (shrink_i) begin
            sub_q  <= sub_q + SUB_W'(2);
        end else if (sub_last) begin
            sub_q  <= '0;
            line_q <= line_last ? '0 : line_q + LINE_W'(1);
        end else begin
            sub_q  <= sub_q + SUB_W'(1);
        end
    end

    // Frame phase in cycles, used for the dead-band decode.
    assign phase = PH_W'(line_q) * PH_W'(SUB_N) + PH_W'(sub_q);

    // Decode the outputs from the chain state.
    always_comb begin
        line_clk_o = (sub_q >= SUB_W'(LINE_DIV));
        cmp8k_o    = (line_q >= LINE_W'(APPLY_LINE));
        strobe_o   = !((phase < PH_W'(DEADBAND)) ||
                       (phase >= PH_W'(FRAME_TICKS - DEADBAND)));
        at_apply_o = (line_q == LINE_W'(APPLY_LINE)) && (sub_q == '0);
        wrap_o     = sub_last && line_last;
    end

    // R4: a stretch leaves the chain where it was
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_i |=> (phase == $past(phase)));

    // R5: a shrink moves the chain two cycles at once within the same line period
    assert_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shrink_i |=> (sub_q == $past(sub_q) + SUB_W'(2)) && (line_q == $past(line_q)));

    // R1: the comparison signal falls only when the frame restarts
    assert_cmp_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp8k_o) |-> (line_q == '0) && (sub_q == '0));

endmodule

// File: rtl/frame_dpll_corrector.sv
// Correction scheduler. On each detected reference fall it turns the sampled
// strobe and comparison level into a decision, and holds it until the chain
// reaches the apply point. At most one correction fires per frame. A decision
// captured in the cycle of an application replaces the applied one and waits
// for the next frame.
module frame_dpll_corrector
    import frame_dpll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic strobe_i,
    input  logic cmp8k_i,
    input  logic at_apply_i,
    input  logic wrap_i,
    output logic stretch_o,
    output logic shrink_o
);

    corr_e pending_q;
    corr_e decision;
    logic  fired_q;
    logic  fire;

    assign decision  = decide(strobe_i, cmp8k_i);
    assign fire      = at_apply_i && !fired_q && (pending_q != CORR_NONE);
    assign stretch_o = fire && (pending_q == CORR_STRETCH);
    assign shrink_o  = fire && (pending_q == CORR_SHRINK);

    // Keep the newest decision; drop it once applied.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_q <= CORR_NONE;
        else if (fall_i) pending_q <= decision;
        else if (fire)   pending_q <= CORR_NONE;
    end

    // Note that this frame's correction is spent; re-arm at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)      fired_q <= 1'b0;
        else if (wrap_i) fired_q <= 1'b0;
        else if (fire)   fired_q <= 1'b1;
    end

    // R6: one correction, never in two adjacent cycles (a held chain stays at the apply point)
    assert_single_corr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_o || shrink_o) |=> !(stretch_o || shrink_o));

    // R7: a capture during an application is kept for later
    assert_keep_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && fire) |=> (pending_q == $past(decision)));

endmodule

// File: rtl/frame_dpll_lock.sv
// Lock monitor. Counts consecutive reference captures that needed no correction
// and raises the flag when LOCK_FRAMES are reached. Any capture that calls for
// a correction clears both the count and the flag.
module frame_dpll_lock #(
    parameter int unsigned LOCK_FRAMES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  logic strobe_i,
    output logic locked_o
);

    localparam int unsigned CNT_W = $clog2(LOCK_FRAMES + 1);

    logic [CNT_W-1:0] run_q;

    // Track the run of quiet frames and derive the flag from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            locked_o <= 1'b0;
        end else if (capture_i) begin
            if (strobe_i) begin
                run_q    <= '0;
                locked_o <= 1'b0;
            end else begin
                if (run_q != CNT_W'(LOCK_FRAMES)) run_q <= run_q + CNT_W'(1);
                locked_o <= (run_q >= CNT_W'(LOCK_FRAMES - 1));
            end
        end
    end

    // R9: the flag only rises on a quiet capture
    assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(capture_i && !strobe_i));

    // R10: a correcting capture clears the flag
    assert_lock_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && strobe_i) |=> !locked_o);

endmodule

// File: rtl/frame_dpll.sv
// Frame-locked digital PLL core, top level.
// Connects the reference synchroniser, the divider chain, the correction
// scheduler and the lock monitor. The clock runs at twice the master rate.
// The defaults give the T1 variant; FRAME_DIV=256, DEADBAND=512 give CEPT.
module frame_dpll #(
    parameter int unsigned LINE_DIV    = 8,
    parameter int unsigned FRAME_DIV   = 193,
    parameter int unsigned DEADBAND    = 4,
    parameter int unsigned LOCK_FRAMES = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_ref_i,
    output logic line_clk_o,
    output logic cmp8k_o,
    output logic locked_o
);

    logic fall;
    logic strobe;
    logic at_apply;
    logic wrap;
    logic stretch;
    logic shrink;

    frame_dpll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (frame_ref_i),
        .fall_o (fall)
    );

    frame_dpll_divider #(
        .LINE_DIV  (LINE_DIV),
        .FRAME_DIV (FRAME_DIV),
        .DEADBAND  (DEADBAND)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .stretch_i  (stretch),
        .shrink_i   (shrink),
        .line_clk_o (line_clk_o),
        .cmp8k_o    (cmp8k_o),
        .strobe_o   (strobe),
        .at_apply_o (at_apply),
        .wrap_o     (wrap)
    );

    frame_dpll_corrector u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .strobe_i   (strobe),
        .cmp8k_i    (cmp8k_o),
        .at_apply_i (at_apply),
        .wrap_i     (wrap),
        .stretch_o  (stretch),
        .shrink_o   (shrink)
    );

    frame_dpll_lock #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (fall),
        .strobe_i  (strobe),
        .locked_o  (locked_o)
    );

endmodule

// File: tb/frame_dpll_bench.sv
// Bench for frame_dpll (T1 defaults). Outputs are sampled at the falling clock edge;
// the reference is driven there as well.
module frame_dpll_bench;

    localparam int LINE_DIV    = 8;
    localparam int FRAME_DIV   = 193;
    localparam int DEADBAND    = 4;
    localparam int LOCK_FRAMES = 8;
    localparam int FRAME       = 2 * LINE_DIV * FRAME_DIV;   // 3088 cycles
    localparam int APPLY       = (FRAME_DIV / 2) * 2 * LINE_DIV; // 1536

    // Vector table: reference-fall offset from a comparison fall, and the
    // expected change of the two-frame span. The judged phase is offset+2.
    localparam int NV = 10;
    localparam int VD[NV] = '{0,  1,  2, 20, 1500, APPLY-2, FRAME-30, FRAME-7, FRAME-6, FRAME-4};
    localparam int VX[NV] = '{0,  0,  1,  1,    1,      -1,       -1,      -1,       0,       0};
    localparam int VR[NV] = '{3,  3,  4,  4,    4,       5,        5,       5,       3,       3};
    // rows: R3 phase 2, R3 phase 3 (inside), R4 phase 4 (edge), R4 phase 22,
    // R4 phase 1502, R5 phase 1536, R5 phase 3060, R5 phase 3083 (edge),
    // R3 phase 3084 (edge), R3 phase 3086

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic line_clk;
    logic cmp8k;
    logic locked;

    always #4 clk = ~clk;

    frame_dpll #(
        .LINE_DIV    (LINE_DIV),
        .FRAME_DIV   (FRAME_DIV),
        .DEADBAND    (DEADBAND),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_frame_dpll (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ref_i (ref_in),
        .line_clk_o  (line_clk),
        .cmp8k_o     (cmp8k),
        .locked_o    (locked)
    );

    int checks = 0;
    int errors = 0;
    int tick = 0;
    int fall_cnt = 0;
    int t_fall[64];
    int rise_last = 0;
    int rise_prev = 0;
    int rises_run = 0;
    int rises_frame = 0;
    logic cmp_prev = 1'b0;
    logic lc_prev = 1'b0;

    // Record comparison falls and line-clock rises with cycle stamps.
    always @(negedge clk) begin
        tick = tick + 1;
        if (cmp_prev && !cmp8k) begin
            fall_cnt = fall_cnt + 1;
            t_fall[fall_cnt % 64] = tick;
            rises_frame = rises_run;
            rises_run = 0;
        end
        if (!lc_prev && line_clk) begin
            rises_run = rises_run + 1;
            rise_prev = rise_last;
            rise_last = tick;
        end
        cmp_prev = cmp8k;
        lc_prev = line_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int span(input int a, input int b);
        return t_fall[b % 64] - t_fall[a % 64];
    endfunction

    // Drop the reference d cycles after the current comparison fall, then raise it.
    task automatic pulse_ref(input int d);
        repeat (d) @(negedge clk);
        ref_in = 1'b0;
        repeat (4) @(negedge clk);
        ref_in = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", tick, 0);
        finish_run();
    end

    initial begin
        int n0;
        int k;
        bit seen_hi;

        // R11: state while in reset
        repeat (5) @(negedge clk);
        check(line_clk == 1'b0, "R11", "line clock in reset", int'(line_clk), 0);
        check(cmp8k == 1'b0,    "R11", "cmp8k in reset",      int'(cmp8k),    0);
        check(locked == 1'b0,   "R11", "lock in reset",       int'(locked),   0);
        rst_n = 1'b1;

        // R2: a rising edge alone must not correct anything
        repeat (50) @(negedge clk);
        ref_in = 1'b1;
        n0 = fall_cnt;
        wait (fall_cnt == n0 + 3);
        check(span(n0 + 2, n0 + 3) == FRAME, "R2", "frame after rising edge",
              span(n0 + 2, n0 + 3), FRAME);
        // R8: constant reference
        check(span(n0 + 1, n0 + 2) == FRAME, "R8", "free-run frame",
              span(n0 + 1, n0 + 2), FRAME);
        check(locked == 1'b0, "R8", "lock with constant reference", int'(locked), 0);
        // R1: division ratios
        check(rises_frame == FRAME_DIV, "R1", "line edges per frame", rises_frame, FRAME_DIV);
        check(rise_last - rise_prev == 2 * LINE_DIV, "R1", "line clock period",
              rise_last - rise_prev, 2 * LINE_DIV);

        // Table walk: R3, R4, R5 and the R6 edge count
        for (int i = 0; i < NV; i++) begin
            n0 = fall_cnt;
            pulse_ref(VD[i]);
            wait (fall_cnt == n0 + 2);
            check(span(n0, n0 + 2) == 2 * FRAME + VX[i], $sformatf("R%0d", VR[i]),
                  $sformatf("two-frame span, offset %0d", VD[i]),
                  span(n0, n0 + 2), 2 * FRAME + VX[i]);
            check(rises_frame == FRAME_DIV, "R6", "line edges in corrected frame",
                  rises_frame, FRAME_DIV);
        end

        // R7: capture in the same cycle as a pending shrink is applied
        n0 = fall_cnt;
        pulse_ref(FRAME - 30);
        wait (fall_cnt == n0 + 1);
        pulse_ref(APPLY - 2);
        wait (fall_cnt == n0 + 3);
        check(span(n0, n0 + 3) == 3 * FRAME - 2, "R7", "three-frame span, two shrinks",
              span(n0, n0 + 3), 3 * FRAME - 2);

        // R10: a correction leaves the flag low; R9: eight quiet frames lock
        n0 = fall_cnt;
        pulse_ref(20);
        repeat (2) @(negedge clk);
        check(locked == 1'b0, "R10", "lock after stretch", int'(locked), 0);
        for (int j = 1; j <= LOCK_FRAMES; j++) begin
            wait (fall_cnt == n0 + j);
            pulse_ref(0);
            repeat (2) @(negedge clk);
            check(locked == (j == LOCK_FRAMES), "R9", $sformatf("lock after %0d quiet frames", j),
                  int'(locked), int'(j == LOCK_FRAMES));
        end

        // R10: a stretch decision drops the flag
        n0 = fall_cnt;
        wait (fall_cnt == n0 + 1);
        repeat (20) @(negedge clk);
        check(locked == 1'b1, "R10", "lock held before correction", int'(locked), 1);
        ref_in = 1'b0;
        repeat (4) @(negedge clk);
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        check(locked == 1'b0, "R10", "lock after correction", int'(locked), 0);

        // R11: reset in mid-run, then time the first fall after release
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cmp8k == 1'b0 && line_clk == 1'b0 && locked == 1'b0, "R11",
              "outputs after mid-run reset", int'({cmp8k, line_clk, locked}), 0);
        rst_n = 1'b1;
        k = 0;
        seen_hi = 1'b0;
        while (!(seen_hi && !cmp8k)) begin
            @(negedge clk);
            k++;
            if (cmp8k) seen_hi = 1'b1;
        end
        check(k == FRAME, "R11", "cycles from release to first fall", k, FRAME);

        finish_run();
    end

endmodule